// File: doc/BRIEF.md
# Auto-incrementing color palette RAM

This block holds the color tables used by a tile and sprite renderer: eight palettes of four colors each, every color a 15-bit RGB word stored as two bytes, 64 bytes in all. The processor reaches the storage through two byte-wide registers. The first is a pointer that selects a byte and carries a flag that makes the pointer step forward after each store. The second is a data window onto the byte the pointer selects. A typical use sets the pointer once with the flag set and then streams a whole palette through the data window.

The renderer reads the storage through a separate, purely combinational port. It presents a palette number and a color number and gets back 24-bit RGB, each 5-bit channel widened to 8 bits by replicating its top bits into the low bits. For software written for an older four-shade display, a compatibility path rebuilds one palette from a 2-bit-per-color shade byte. Each shade code selects one of four stored base colors.

Top module: `color_palette_ram`

## Requirements
- R1: Writing the pointer register (`cpu_sel`=0) loads the byte address from bits 5:0 and the step flag from bit 7. Bit 6 always reads back as 0, so writing 0xFF reads back 0xBF.
- R2: A data write (`cpu_sel`=1) with the step flag set stores the byte and then advances the address by one modulo 64, so address 63 wraps to 0. The flag stays set.
- R3: A data write with the step flag clear stores the byte and leaves the pointer unchanged.
- R4: Reading the data window returns the byte at the current address. Any number of reads leaves the pointer unchanged.
- R5: Color c of palette p is held at byte p*8+2c (low byte) and byte p*8+2c+1 (high byte).
- R6: Inside a color word, red occupies bits 4:0, green bits 9:5 and blue bits 14:10. Bit 15 is ignored.
- R7: `pix_rgb` is {R8,G8,B8} with red in bits 23:16. Each 8-bit channel equals (x<<3)|(x>>2) of its 5-bit value x.
- R8: When `compat_en`=1, a `shade_wr` pulse rewrites all 8 bytes of palette `shade_pal`. Color c takes code `shade_val`[2c+1:2c], and code k selects base color k. The defaults are 0x7FFF, 0x6318, 0x318C and 0x0000 for codes 0 to 3.
- R9: When `compat_en`=0, `shade_wr` is ignored and no byte changes.
- R10: If a data write and a shade load hit the same palette in one cycle, the shade load's bytes win. The pointer still advances as R2 and R3 say.
- R11: A store shows on `pix_rgb` and `cpu_rdata` in the cycle after the edge that accepts it.
- R12: Reset clears the pointer register and all 64 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register select: 0 pointer, 1 data window |
| cpu_wr | input | 1 | Write strobe for the selected register |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Selected register's value (combinational) |
| compat_en | input | 1 | Enables the shade-byte load path |
| shade_wr | input | 1 | Shade-byte load strobe |
| shade_pal | input | 3 | Palette that the shade load rewrites |
| shade_val | input | 8 | Four 2-bit shade codes, color 0 in bits 1:0 |
| pix_pal | input | 3 | Renderer palette number |
| pix_col | input | 2 | Renderer color number |
| pix_rgb | output | 24 | Widened RGB of the selected color |

## Verification
A pointer that steps wrongly or fails to wrap shows up as soon as the next byte is streamed. The stored bytes land one slot off, and both the data window and the pointer readback show it in the following cycle. A bad layout or channel swap appears on `pix_rgb` in the cycle after the second byte of a color is written. A mis-routed shade load shows as wrong bytes across a whole palette, visible one cycle after the strobe.

// File: rtl/cpal_pkg.sv
`timescale 1ns/1ps
package cpal_pkg;

  localparam int BYTE_W    = 8;
  localparam int CHAN_W    = 5;
  localparam int WORD_W    = 15;
  localparam int STEP_BIT  = 7;

  // 5-bit channel to 8 bits: shift up and refill the low bits from the top
  function automatic logic [7:0] widen5(input logic [CHAN_W-1:0] x);
    return {x, 3'b000} | {5'b00000, x[4:2]};
  endfunction

  // 15-bit word with red low to {R8,G8,B8}
  function automatic logic [23:0] word_to_rgb(input logic [WORD_W-1:0] w);
    return {widen5(w[4:0]), widen5(w[9:5]), widen5(w[14:10])};
  endfunction

endpackage

// File: rtl/cpal_index.sv
`timescale 1ns/1ps
module cpal_index #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic              data_wr,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] addr,
  output logic              step_en,
  output logic [7:0]        idx_byte
);
  localparam int PAD_W = 7 - ADDR_W;

  logic [ADDR_W-1:0] addr_q;
  logic              step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= 1'b0;
    end else if (idx_wr) begin
      addr_q <= wdata[ADDR_W-1:0];
      step_q <= wdata[cpal_pkg::STEP_BIT];
    end else if (data_wr && step_q) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr     = addr_q;
  assign step_en  = step_q;
  assign idx_byte = {step_q, {PAD_W{1'b0}}, addr_q};
endmodule

// File: rtl/cpal_shade_remap.sv
`timescale 1ns/1ps
module cpal_shade_remap #(
  parameter int NUM_COLORS = 4,
  parameter logic [3:0][14:0] BASE = {15'h0000, 15'h318C, 15'h6318, 15'h7FFF}
) (
  input  logic [2*NUM_COLORS-1:0]  shade_val,
  output logic [16*NUM_COLORS-1:0] slot_bytes
);
  for (genvar c = 0; c < NUM_COLORS; c++) begin : g_col
    logic [1:0] code;
    assign code = shade_val[2*c +: 2];
    assign slot_bytes[16*c +: 16] = {1'b0, BASE[code]};
  end
endmodule

// File: rtl/cpal_store.sv
`timescale 1ns/1ps
module cpal_store #(
  parameter int NUM_BYTES = 64,
  parameter int PAL_BYTES = 8,
  parameter int ADDR_W    = 6,
  parameter int PAL_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [7:0]              cpu_wdata,
  input  logic                    slot_we,
  input  logic [PAL_W-1:0]        slot_idx,
  input  logic [8*PAL_BYTES-1:0]  slot_bytes,
  output logic [8*NUM_BYTES-1:0]  mem_flat
);
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam logic [PAL_W-1:0]  MY_PAL  = PAL_W'(i / PAL_BYTES);
    localparam int                MY_OFF  = i % PAL_BYTES;
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             q <= 8'h00;
      else if (slot_we && slot_idx == MY_PAL) q <= slot_bytes[8*MY_OFF +: 8];
      else if (cpu_we && cpu_addr == MY_ADDR) q <= cpu_wdata;
    end
    assign mem_flat[8*i +: 8] = q;
  end
endmodule

// File: rtl/cpal_pixel_read.sv
`timescale 1ns/1ps
module cpal_pixel_read #(
  parameter int NUM_BYTES = 64,
  parameter int PAL_W     = 3,
  parameter int COL_W     = 2
) (
  input  logic [8*NUM_BYTES-1:0] mem_flat,
  input  logic [PAL_W-1:0]       pal,
  input  logic [COL_W-1:0]       col,
  output logic [23:0]            rgb
);
  logic [PAL_W+COL_W:0] lo_addr;
  logic [7:0]           lo_b, hi_b;

  assign lo_addr = {pal, col, 1'b0};
  assign lo_b    = mem_flat[{lo_addr, 3'b000} +: 8];
  assign hi_b    = mem_flat[{lo_addr | 1'b1, 3'b000} +: 8];
  assign rgb     = cpal_pkg::word_to_rgb({hi_b[6:0], lo_b});
endmodule

// File: rtl/color_palette_ram.sv
`timescale 1ns/1ps
module color_palette_ram #(
  parameter int NUM_PALS   = 8,
  parameter int NUM_COLORS = 4,
  parameter logic [3:0][14:0] BASE_SHADES = {15'h0000, 15'h318C, 15'h6318, 15'h7FFF}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_sel,
  input  logic                        cpu_wr,
  input  logic [7:0]                  cpu_wdata,
  output logic [7:0]                  cpu_rdata,
  input  logic                        compat_en,
  input  logic                        shade_wr,
  input  logic [$clog2(NUM_PALS)-1:0] shade_pal,
  input  logic [2*NUM_COLORS-1:0]     shade_val,
  input  logic [$clog2(NUM_PALS)-1:0] pix_pal,
  input  logic [$clog2(NUM_COLORS)-1:0] pix_col,
  output logic [23:0]                 pix_rgb
);
  localparam int PAL_W     = $clog2(NUM_PALS);
  localparam int COL_W     = $clog2(NUM_COLORS);
  localparam int PAL_BYTES = 2 * NUM_COLORS;
  localparam int NUM_BYTES = NUM_PALS * PAL_BYTES;
  localparam int ADDR_W    = $clog2(NUM_BYTES);

  // named events for the checker
  logic evt_idx_wr, evt_data_wr, evt_slot_ld;
  assign evt_idx_wr  = cpu_wr & ~cpu_sel;
  assign evt_data_wr = cpu_wr &  cpu_sel;
  assign evt_slot_ld = shade_wr & compat_en;

  logic [ADDR_W-1:0]      cur_addr;
  logic                   step_en;
  logic [7:0]             idx_byte;
  logic [8*PAL_BYTES-1:0] slot_bytes;
  logic [8*NUM_BYTES-1:0] mem_flat;

  cpal_index #(.ADDR_W(ADDR_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .idx_wr(evt_idx_wr), .data_wr(evt_data_wr),
    .wdata(cpu_wdata), .addr(cur_addr), .step_en(step_en), .idx_byte(idx_byte)
  );

  cpal_shade_remap #(.NUM_COLORS(NUM_COLORS), .BASE(BASE_SHADES)) u_remap (
    .shade_val(shade_val), .slot_bytes(slot_bytes)
  );

  cpal_store #(.NUM_BYTES(NUM_BYTES), .PAL_BYTES(PAL_BYTES),
               .ADDR_W(ADDR_W), .PAL_W(PAL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cpu_we(evt_data_wr), .cpu_addr(cur_addr),
    .cpu_wdata(cpu_wdata), .slot_we(evt_slot_ld), .slot_idx(shade_pal),
    .slot_bytes(slot_bytes), .mem_flat(mem_flat)
  );

  cpal_pixel_read #(.NUM_BYTES(NUM_BYTES), .PAL_W(PAL_W), .COL_W(COL_W)) u_pix (
    .mem_flat(mem_flat), .pal(pix_pal), .col(pix_col), .rgb(pix_rgb)
  );

  logic [7:0] data_byte;
  assign data_byte = mem_flat[{cur_addr, 3'b000} +: 8];
  assign cpu_rdata = cpu_sel ? data_byte : idx_byte;
endmodule

// File: rtl/cpal_checker.sv
`timescale 1ns/1ps
module cpal_checker #(
  parameter int NUM_BYTES = 64,
  parameter int ADDR_W    = 6,
  parameter int PAL_W     = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   evt_idx_wr,
  input logic                   evt_data_wr,
  input logic                   evt_slot_ld,
  input logic [PAL_W-1:0]       shade_pal,
  input logic [7:0]             cpu_wdata,
  input logic [7:0]             idx_byte,
  input logic [8*NUM_BYTES-1:0] mem_flat,
  input logic [23:0]            pix_rgb
);
  logic [ADDR_W-1:0] cur_a;
  assign cur_a = idx_byte[ADDR_W-1:0];

  // remember the last CPU store that no shade load overrode
  logic              pend;
  logic [ADDR_W-1:0] pend_a;
  logic [7:0]        pend_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_a <= '0; pend_d <= '0;
    end else begin
      pend   <= evt_data_wr && !(evt_slot_ld && cur_a[ADDR_W-1 -: PAL_W] == shade_pal);
      pend_a <= cur_a;
      pend_d <= cpu_wdata;
    end
  end
  logic [7:0] stored;
  assign stored = mem_flat[{pend_a, 3'b000} +: 8];

  a_r1_bit6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    idx_byte[6] == 1'b0);

  a_r2_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_data_wr && idx_byte[7]) |=>
      (idx_byte[7] && cur_a == ADDR_W'($past(cur_a) + 1'b1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_data_wr && !idx_byte[7]) |=> $stable(idx_byte));

  a_r11_store_visible: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> stored == pend_d);

  a_r7_widen: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rgb[18:16] == pix_rgb[23:21] && pix_rgb[10:8] == pix_rgb[15:13] &&
    pix_rgb[2:0] == pix_rgb[7:5]);
endmodule

bind color_palette_ram cpal_checker #(
  .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .PAL_W(PAL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_idx_wr(evt_idx_wr), .evt_data_wr(evt_data_wr),
  .evt_slot_ld(evt_slot_ld), .shade_pal(shade_pal), .cpu_wdata(cpu_wdata),
  .idx_byte(idx_byte), .mem_flat(mem_flat), .pix_rgb(pix_rgb)
);

// File: tb/sim_color_palette_ram.sv
`timescale 1ns/1ps
module sim_color_palette_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic compat_en = 1'b0, shade_wr = 1'b0;
  logic [2:0] shade_pal = 3'd0;
  logic [7:0] shade_val = 8'h00;
  logic [2:0] pix_pal = 3'd0;
  logic [1:0] pix_col = 2'd0;
  logic [23:0] pix_rgb;

  int n_run = 0, n_fail = 0;
  logic [7:0] ref_mem [64];
  logic [15:0] base_ref [4];

  always #4 clk = ~clk;

  color_palette_ram u0 (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .compat_en(compat_en),
    .shade_wr(shade_wr), .shade_pal(shade_pal), .shade_val(shade_val),
    .pix_pal(pix_pal), .pix_col(pix_col), .pix_rgb(pix_rgb)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // bench-side channel widening: replicate the top three bits
  function automatic logic [7:0] grow(input logic [4:0] v);
    return {v, v[4], v[3], v[2]};
  endfunction

  function automatic logic [23:0] ref_rgb(input int p, input int c);
    logic [15:0] w;
    w = {ref_mem[p*8 + c*2 + 1], ref_mem[p*8 + c*2]};
    return {grow(w[4:0]), grow(w[9:5]), grow(w[14:10])};
  endfunction

  task automatic cpu_write(input logic sel, input logic [7:0] v);
    @(negedge clk);
    cpu_sel = sel; cpu_wr = 1'b1; cpu_wdata = v;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic sel, output logic [7:0] v);
    cpu_sel = sel;
    #1;
    v = cpu_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    cpu_read(1'b0, v); check("R12 pointer", v, 8'h00);
    cpu_read(1'b1, v); check("R12 data", v, 8'h00);
    pix_pal = 3'd7; pix_col = 2'd3; #1;
    check("R12 pixel", pix_rgb, 24'h0);
  endtask

  task automatic t_pointer;
    logic [7:0] v;
    cpu_write(1'b0, 8'hFF);
    cpu_read(1'b0, v); check("R1 bit6 cleared", v, 8'hBF);
    cpu_write(1'b0, 8'h15);
    cpu_read(1'b0, v); check("R1 plain load", v, 8'h15);
  endtask

  task automatic t_stream;
    logic [7:0] v;
    cpu_write(1'b0, 8'h80 | 8'd5);
    cpu_write(1'b1, 8'hA1); cpu_write(1'b1, 8'hA2); cpu_write(1'b1, 8'hA3);
    ref_mem[5] = 8'hA1; ref_mem[6] = 8'hA2; ref_mem[7] = 8'hA3;
    cpu_read(1'b0, v); check("R2 advanced pointer", v, 8'h88);
    for (int k = 5; k < 8; k++) begin
      cpu_write(1'b0, 8'(k));
      cpu_read(1'b1, v); check("R2 streamed byte", v, ref_mem[k]);
    end
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    cpu_write(1'b0, 8'hBF);
    cpu_write(1'b1, 8'h5C); ref_mem[63] = 8'h5C;
    cpu_read(1'b0, v); check("R2 wrap 63 to 0", v, 8'h80);
    cpu_write(1'b0, 8'h3F);
    cpu_read(1'b1, v); check("R2 wrap byte stored", v, 8'h5C);
  endtask

  task automatic t_hold_and_read;
    logic [7:0] v;
    cpu_write(1'b0, 8'h20);
    cpu_write(1'b1, 8'h11); cpu_write(1'b1, 8'h22); ref_mem[32] = 8'h22;
    cpu_read(1'b0, v); check("R3 pointer held", v, 8'h20);
    cpu_read(1'b1, v); check("R3 last write wins", v, 8'h22);
    cpu_read(1'b1, v); @(negedge clk); cpu_read(1'b1, v); @(negedge clk);
    cpu_read(1'b0, v); check("R4 reads do not advance", v, 8'h20);
  endtask

  task automatic t_color_layout;
    // palette 3 color 2 -> bytes 28 and 29; word red 1F, green 0A, blue 11
    logic [15:0] w;
    w = {1'b1, 5'h11, 5'h0A, 5'h1F};
    pix_pal = 3'd3; pix_col = 2'd2;
    cpu_write(1'b0, 8'h80 | 8'd28);
    cpu_write(1'b1, w[7:0]); ref_mem[28] = w[7:0];
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_wdata = w[15:8];
    @(posedge clk); #1;
    cpu_wr = 1'b0; ref_mem[29] = w[15:8];
    check("R11 visible after edge", pix_rgb, ref_rgb(3, 2));
    check("R5 R6 R7 layout and widening", pix_rgb, 24'hFF528C);
    pix_col = 2'd1; #1;
    check("R5 neighbour color untouched", pix_rgb, ref_rgb(3, 1));
  endtask

  task automatic t_shade(input logic en, input logic [2:0] p, input logic [7:0] sv);
    logic [7:0] v;
    @(negedge clk);
    compat_en = en; shade_wr = 1'b1; shade_pal = p; shade_val = sv;
    @(negedge clk);
    shade_wr = 1'b0;
    if (en) for (int c = 0; c < 4; c++) begin
      logic [15:0] b;
      b = base_ref[sv[2*c +: 2]];
      ref_mem[p*8 + c*2] = b[7:0]; ref_mem[p*8 + c*2 + 1] = b[15:8];
    end
    for (int k = 0; k < 8; k++) begin
      cpu_write(1'b0, 8'(p*8 + k));
      cpu_read(1'b1, v);
      check(en ? "R8 shade load byte" : "R9 load ignored", v, ref_mem[p*8 + k]);
    end
    pix_pal = p; pix_col = 2'd1; #1;
    check(en ? "R8 shade pixel" : "R9 pixel unchanged", pix_rgb, ref_rgb(p, 1));
  endtask

  task automatic t_collide;
    logic [7:0] v;
    cpu_write(1'b0, 8'h80 | 8'd17);
    @(negedge clk);
    compat_en = 1'b1; shade_wr = 1'b1; shade_pal = 3'd2; shade_val = 8'h1B;
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h77;
    @(negedge clk);
    shade_wr = 1'b0; cpu_wr = 1'b0;
    // code for color 0 is 3 (black): byte 17 is the high byte of color 0
    cpu_read(1'b0, v); check("R10 pointer still advances", v, 8'h80 | 8'd18);
    cpu_write(1'b0, 8'd17);
    cpu_read(1'b1, v); check("R10 shade load wins", v, 8'h00);
    cpu_write(1'b0, 8'd19);
    cpu_read(1'b1, v); check("R10 other color from load", v, 8'h31);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    base_ref[0] = 16'h7FFF; base_ref[1] = 16'h6318;
    base_ref[2] = 16'h318C; base_ref[3] = 16'h0000;
    for (int k = 0; k < 64; k++) ref_mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_stream();
    t_wrap();
    t_hold_and_read();
    t_color_layout();
    t_shade(1'b1, 3'd1, 8'hE4);
    t_shade(1'b0, 3'd1, 8'h00);
    t_shade(1'b1, 3'd6, 8'h4E);
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule